// File: doc/BRIEF.md
# Burst Refresh Request Tracker

This block decides when a dynamic memory needs a refresh cycle and remembers how many it owes. A slow refresh clock, already brought into the controller clock domain as a one-cycle tick, is divided down so that every sixty-fourth tick raises one refresh request. A page-mode access can hold the memory for a long time. While it runs, requests that the access sequencer cannot serve are logged in a saturating counter of up to 128 entries.

The block keeps its pending flag high until the log is empty. When the access ends, the sequencer can therefore run refresh cycles back to back, raising a done strobe after each one. The block also holds the row address used for refresh. That address comes up all ones after reset and steps up by one for every refresh the block accepts, so the first refreshed row is zero.

The block does not generate memory timing. It only tracks requests and supplies the row for the next refresh.

Top module: `burst_refresh_tracker`

## Requirements
- R1: After reset the pending count is 0, the pending flag is low and the refresh row is all ones (10'h3FF).
- R2: One refresh request is generated on the cycle of every 64th refresh tick counted since reset. Cycles without a tick do not advance the divider. The request shows in the pending count on the next cycle.
- R3: A request in a cycle with no accepted done strobe raises the pending count by one on the next cycle, as long as the count is below 128.
- R4: The pending count never exceeds 128. A request that arrives while the count is 128, with no accepted done strobe, is dropped and the count holds at 128.
- R5: A done strobe while the count is nonzero and no request arrives lowers the count by one. Every accepted done strobe advances the refresh row by one on the next cycle.
- R6: A done strobe while the count is 0 and no request arrives is ignored: the count stays 0 and the refresh row does not change.
- R7: When a request and a done strobe arrive in the same cycle, the done strobe is accepted and the pending count is unchanged, whatever its value (0 and 128 included). The refresh row advances by one.
- R8: The pending flag is high exactly when the pending count is nonzero.
- R9: The refresh row wraps from all ones to zero, so the first accepted done strobe after reset yields row 0.
- R10: Done strobes on consecutive cycles drain the log one entry per cycle down to 0, and each one advances the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfclk_tick | input | 1 | One-cycle pulse per refresh clock period, already synchronous to clk |
| refresh_done | input | 1 | One-cycle strobe from the sequencer when a refresh cycle finishes |
| refresh_pending | output | 1 | High while at least one refresh is owed |
| refresh_row | output | 10 | Row address for the next refresh cycle |
| pending_count | output | 8 | Number of refreshes owed, 0 to 128 |

## Verification
The bench targets several corner cases. It checks the divider edge at 63 against 64 ticks, with idle cycles mixed in; a divider that counts cycles instead of ticks, or that is off by one, moves the first request. It checks a simultaneous request and done at a count of 0 and at a count of 1; a design that handled these two inputs in the wrong order would lose a refresh or log a phantom one. It fills the log to 128 and sends one more request, which exposes a counter that wraps to zero or a limit of 127. It also checks the first done after reset and a done with an empty log, which catch a row that starts at zero or advances on an unaccepted strobe.

// File: rtl/burst_refresh_pkg.sv
package burst_refresh_pkg;

  typedef enum logic [1:0] {
    PEND_HOLD = 2'd0,
    PEND_INC  = 2'd1,
    PEND_DEC  = 2'd2
  } pend_act_e;

  // Chooses what the log does in one cycle. A request together with an
  // accepted done cancels out; a request at the limit is dropped.
  function automatic pend_act_e pick_action(input logic req,
                                            input logic done_ok,
                                            input logic at_limit);
    pend_act_e act;
    if (req && done_ok)        act = PEND_HOLD;
    else if (req && !at_limit) act = PEND_INC;
    else if (done_ok)          act = PEND_DEC;
    else                       act = PEND_HOLD;
    return act;
  endfunction

endpackage

// File: rtl/rfr_tick_divider.sv
module rfr_tick_divider #(
  parameter int DIV_RATIO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic req
);
  localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] phase_q;
  logic          wrap;

  assign wrap = (phase_q == LAST);
  assign req  = tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= wrap ? '0 : phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/rfr_pending_log.sv
module rfr_pending_log
  import burst_refresh_pkg::*;
#(
  parameter int MAX_PENDING = 128,
  parameter int PW          = $clog2(MAX_PENDING + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          done,
  output logic          done_ok,
  output logic          pending,
  output logic [PW-1:0] count
);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PENDING);

  logic      at_limit;
  logic      owes;
  pend_act_e act;

  assign owes     = (count != '0);
  assign at_limit = (count == LIMIT);
  assign done_ok  = done && (owes || req);
  assign act      = pick_action(req, done_ok, at_limit);
  assign pending  = owes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case (act)
        PEND_INC: count <= count + PW'(1);
        PEND_DEC: count <= count - PW'(1);
        default:  count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rfr_row_counter.sv
module rfr_row_counter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '1;
    end else if (step) begin
      row <= row + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/burst_refresh_tracker.sv
module burst_refresh_tracker #(
  parameter int DIV_RATIO   = 64,
  parameter int MAX_PENDING = 128,
  parameter int ADDR_W      = 10
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rfclk_tick,
  input  logic                               refresh_done,
  output logic                               refresh_pending,
  output logic [ADDR_W-1:0]                  refresh_row,
  output logic [$clog2(MAX_PENDING+1)-1:0]   pending_count
);
  localparam int PW = $clog2(MAX_PENDING + 1);

  // Internal events, named so the bound checker can see them.
  logic div_req;
  logic done_ok;

  rfr_tick_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (rfclk_tick),
    .req  (div_req)
  );

  rfr_pending_log #(.MAX_PENDING(MAX_PENDING), .PW(PW)) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (div_req),
    .done   (refresh_done),
    .done_ok(done_ok),
    .pending(refresh_pending),
    .count  (pending_count)
  );

  rfr_row_counter #(.ADDR_W(ADDR_W)) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .step (done_ok),
    .row  (refresh_row)
  );
endmodule

// File: rtl/burst_refresh_tracker_chk.sv
module burst_refresh_tracker_chk #(
  parameter int MAX_PENDING = 128,
  parameter int ADDR_W      = 10,
  parameter int PW          = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              done,
  input logic              div_req,
  input logic              done_ok,
  input logic              pending,
  input logic [PW-1:0]     count,
  input logic [ADDR_W-1:0] row
);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PENDING);

  assert_req_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_req |-> tick);

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req && !done_ok && count != LIMIT) |=> count == $past(count) + PW'(1));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT);

  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req && !done_ok && count == LIMIT) |=> $stable(count));

  assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && !div_req) |=> count == $past(count) - PW'(1));

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> row == $past(row) + ADDR_W'(1));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |=> ($stable(row) && $stable(count)));

  assert_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_req && done_ok) |=> $stable(count));

  assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(div_req));

  assert_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(done_ok));
endmodule

bind burst_refresh_tracker burst_refresh_tracker_chk #(
  .MAX_PENDING(MAX_PENDING),
  .ADDR_W     (ADDR_W),
  .PW         (PW)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (rfclk_tick),
  .done   (refresh_done),
  .div_req(div_req),
  .done_ok(done_ok),
  .pending(refresh_pending),
  .count  (pending_count),
  .row    (refresh_row)
);

// File: tb/burst_refresh_tracker_bench.sv
module burst_refresh_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfclk_tick = 1'b0;
  logic       refresh_done = 1'b0;
  logic       refresh_pending;
  logic [9:0] refresh_row;
  logic [7:0] pending_count;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  burst_refresh_tracker u_burst_refresh_tracker (
    .clk            (clk),
    .rst_n          (rst_n),
    .rfclk_tick     (rfclk_tick),
    .refresh_done   (refresh_done),
    .refresh_pending(refresh_pending),
    .refresh_row    (refresh_row),
    .pending_count  (pending_count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at a falling edge; drives inputs for one rising edge and
  // returns at the next falling edge with outputs settled.
  task automatic step(input logic t, input logic d);
    rfclk_tick   = t;
    refresh_done = d;
    @(negedge clk);
    rfclk_tick   = 1'b0;
    refresh_done = 1'b0;
  endtask

  task automatic ticks(input int n, input bool_gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      if (bool_gap != 0 && (i % 5) == 0) step(1'b0, 1'b0);
    end
  endtask

  task automatic t_reset();
    chk("R1 count", pending_count, 0);
    chk("R1 flag", refresh_pending, 0);
    chk("R1 row", refresh_row, 10'h3FF);
  endtask

  task automatic t_divider();
    ticks(63, 1);
    step(1'b0, 1'b0);
    chk("R2 no request after 63 ticks", pending_count, 0);
    step(1'b1, 1'b0);
    chk("R2 R3 request on tick 64", pending_count, 1);
    chk("R8 flag with count 1", refresh_pending, 1);
  endtask

  task automatic t_first_done();
    step(1'b0, 1'b1);
    chk("R5 count after done", pending_count, 0);
    chk("R9 row wraps to 0", refresh_row, 0);
    chk("R8 flag with count 0", refresh_pending, 0);
  endtask

  task automatic t_ignored_done();
    step(1'b0, 1'b1);
    chk("R6 count stays 0", pending_count, 0);
    chk("R6 row unchanged", refresh_row, 0);
  endtask

  task automatic t_drain();
    ticks(192, 0);
    chk("R3 three requests logged", pending_count, 3);
    for (int k = 1; k <= 3; k++) begin
      step(1'b0, 1'b1);
      chk("R10 drain count", pending_count, 3 - k);
      chk("R10 drain row", refresh_row, k);
    end
  endtask

  task automatic t_simultaneous();
    ticks(63, 0);
    step(1'b1, 1'b1);
    chk("R7 both at count 0", pending_count, 0);
    chk("R7 row advances at count 0", refresh_row, 4);
    ticks(64, 0);
    ticks(63, 0);
    step(1'b1, 1'b1);
    chk("R7 both at count 1", pending_count, 1);
    chk("R7 row advances at count 1", refresh_row, 5);
    step(1'b0, 1'b1);
    chk("R5 done clears", pending_count, 0);
    chk("R5 row after done", refresh_row, 6);
  endtask

  task automatic t_saturate();
    ticks(128 * 64, 0);
    chk("R4 full at 128", pending_count, 128);
    ticks(64, 0);
    chk("R4 extra request dropped", pending_count, 128);
    ticks(63, 0);
    step(1'b1, 1'b1);
    chk("R7 both at 128", pending_count, 128);
    chk("R7 row at 128", refresh_row, 7);
    step(1'b0, 1'b1);
    chk("R5 done from 128", pending_count, 127);
    for (int k = 0; k < 127; k++) step(1'b0, 1'b1);
    chk("R10 long drain count", pending_count, 0);
    chk("R10 long drain row", refresh_row, 135);
    chk("R8 flag after drain", refresh_pending, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divider();
    t_first_done();
    t_ignored_done();
    t_drain();
    t_simultaneous();
    t_saturate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule